// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transceiver

This block is a full-duplex serial master. It has one shift register, with a transmit holding register in front of it and a receive holding register behind it. Software writes a byte to the data address. The unit copies that byte into the shift register and clocks it out MSB first on `sdo`. At the same time it shifts in `sdi`, and when the frame completes it places the received byte in the receive holding register.

Four status flags coordinate software and hardware:

- transmit-empty (TDRE)
- receive-full (RDRF)
- overrun (ORER)
- transmit-end (TEND)

Because the holding register is free again as soon as a frame starts shifting, software can queue the next byte early. Queued frames then follow each other with no idle clocks. If a new byte is received while the previous one is still unread, the unit flags an overrun and stops transferring until software clears the flag.

The serial clock idles high. Its frequency is the system clock divided by an even ratio that software sets. Register access is a single-cycle write/read strobe pair with a 2-bit address. Read data is combinational.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the status register (address 3) reads 0x01: bit 0 TDRE=1, bit 1 RDRF=0, bit 2 ORER=0, bit 3 TEND=0. `sck` is 1, `sdo` is 0, and both interrupt outputs are 0.
- R2: `sck` idles high and makes exactly 8 low/high pulses per frame. Each serial bit lasts 2*(DIV+1) system clocks, where DIV is the value written to address 1, bits [3:0].
- R3: Data goes out MSB first. `sdo` changes only on falling `sck` edges. `sdi` is sampled on rising edges and assembled MSB first.
- R4: Writing address 2 while TDRE=1 loads the byte and clears TDRE. A write to address 2 while TDRE=0 is ignored, and the byte already queued is the one transmitted.
- R5: A queued byte starts a frame only while at least one enable is set and ORER=0. The enables are in the control register (address 0): bit 0 transmit enable, bit 1 receive enable. When the byte moves to the shift register, TDRE returns to 1.
- R6: At the 8th rising `sck` edge, if receive is enabled and RDRF=0, the received byte is stored and RDRF is set. Reading address 2 returns that byte and clears RDRF.
- R7: If RDRF=1 at the 8th rising edge, ORER is set and the stored byte is kept. While ORER=1 no frame starts. Clearing ORER lets a queued byte start.
- R8: At the end of a frame, TEND is set if TDRE=1. If TDRE=0, the next frame's first falling edge comes 2*(DIV+1) clocks after the last one, with no idle gap.
- R9: Writing the status register clears RDRF, ORER and TEND where the written bit is 0 and leaves them unchanged where it is 1. TDRE is not affected by status writes.
- R10: `irq_rx` equals RDRF AND receive enable. `irq_tx` equals TDRE AND transmit enable.
- R11: With transmit disabled, `sdo` stays 0 throughout a frame. With receive disabled, a frame does not set RDRF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 2) |
| reg_addr | input | 2 | Register address: 0 control, 1 divider, 2 data, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| sck | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive-ready request |
| irq_tx | output | 1 | Transmit-empty request |

## Verification
A corrupted bit counter or a wrong divider count shows up on `sck` within one frame. It appears as a pulse count other than eight or a bit period that differs from 2*(DIV+1). Both are measured edge by edge, including across the boundary of back-to-back frames. A wrong flag update shows up on the status register at the very next poll after the frame ends. For example, a missed overrun leaves ORER clear and overwrites the unread byte, and a lost halt produces extra `sck` pulses within a few tens of clocks. A shift-direction or sampling-edge error corrupts the captured `sdo` byte or the received byte of the same frame.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int unsigned ST_TDRE = 0;
    localparam int unsigned ST_RDRF = 1;
    localparam int unsigned ST_ORER = 2;
    localparam int unsigned ST_TEND = 3;
    localparam int unsigned ST_W    = 4;

    typedef struct packed {
        logic tend;
        logic orer;
        logic rdrf;
        logic tdre;
    } stat_t;
endpackage

// File: rtl/ssx_baud.sv
module ssx_baud #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t s_q, s_d;

    // half-period counter: counts 0..div while the shifter runs
    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == div) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign tick = run && (s_q.cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              can_start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sdi,
    input  logic              tx_en,
    output logic              sck,
    output logic              sdo,
    output logic              busy,
    output logic              load,
    output logic              rx_strobe,
    output logic [DATA_W-1:0] rx_word,
    output logic              frame_done
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [DATA_W-1:0] sr;
        logic              samp;
        logic [BIT_W-1:0]  bitn;
    } shf_t;

    shf_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        load       = 1'b0;
        rx_strobe  = 1'b0;
        frame_done = 1'b0;
        rx_word    = {s_q.sr[DATA_W-2:0], sdi};
        if (!s_q.busy) begin
            if (can_start) begin
                s_d.busy = 1'b1;
                s_d.sck  = 1'b0;
                s_d.sr   = tx_word;
                s_d.bitn = '0;
                load     = 1'b1;
            end
        end else if (tick) begin
            if (!s_q.sck) begin
                // rising edge: capture the input bit
                s_d.sck  = 1'b1;
                s_d.samp = sdi;
                if (s_q.bitn == LAST_BIT) rx_strobe = 1'b1;
            end else if (s_q.bitn != LAST_BIT) begin
                // falling edge: advance to the next bit
                s_d.sck  = 1'b0;
                s_d.sr   = {s_q.sr[DATA_W-2:0], s_q.samp};
                s_d.bitn = s_q.bitn + 1'b1;
            end else if (can_start) begin
                // back-to-back frame, no idle clock
                s_d.sck  = 1'b0;
                s_d.sr   = tx_word;
                s_d.bitn = '0;
                load     = 1'b1;
            end else begin
                s_d.busy   = 1'b0;
                frame_done = 1'b1;
            end
        end
    end

    assign sck  = s_q.sck;
    assign busy = s_q.busy;
    assign sdo  = tx_en & s_q.sr[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.sck <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ssx_regs.sv
module ssx_regs
    import ssx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              load,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              frame_done,
    output logic [DATA_W-1:0] tx_word,
    output logic              can_start,
    output logic              tx_en,
    output logic              rx_en,
    output logic [DIV_W-1:0]  div,
    output logic              irq_rx,
    output logic              irq_tx,
    output stat_t             st
);
    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] rxbuf;
        stat_t             st;
    } reg_t;

    reg_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        // software side
        if (wr && addr == A_CTRL) begin
            s_d.tx_en = wdata[0];
            s_d.rx_en = wdata[1];
        end
        if (wr && addr == A_DIV) s_d.div = wdata[DIV_W-1:0];
        if (wr && addr == A_DATA && s_q.st.tdre) begin
            s_d.txbuf   = wdata;
            s_d.st.tdre = 1'b0;
        end
        if (wr && addr == A_STAT) begin
            s_d.st.rdrf = s_q.st.rdrf & wdata[ST_RDRF];
            s_d.st.orer = s_q.st.orer & wdata[ST_ORER];
            s_d.st.tend = s_q.st.tend & wdata[ST_TEND];
        end
        if (rd && addr == A_DATA) s_d.st.rdrf = 1'b0;
        // hardware side wins over software clears
        if (load) s_d.st.tdre = 1'b1;
        if (rx_strobe && s_q.rx_en) begin
            if (s_q.st.rdrf) begin
                s_d.st.orer = 1'b1;
            end else begin
                s_d.rxbuf   = rx_word;
                s_d.st.rdrf = 1'b1;
            end
        end
        if (frame_done && s_q.st.tdre) s_d.st.tend = 1'b1;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[1:0]       = {s_q.rx_en, s_q.tx_en};
            A_DIV:   rdata[DIV_W-1:0] = s_q.div;
            A_DATA:  rdata            = s_q.rxbuf;
            default: rdata[ST_W-1:0]  = s_q.st;
        endcase
    end

    assign tx_word   = s_q.txbuf;
    assign can_start = !s_q.st.tdre && !s_q.st.orer && (s_q.tx_en || s_q.rx_en);
    assign tx_en     = s_q.tx_en;
    assign rx_en     = s_q.rx_en;
    assign div       = s_q.div;
    assign irq_rx    = s_q.st.rdrf & s_q.rx_en;
    assign irq_tx    = s_q.st.tdre & s_q.tx_en;
    assign st        = s_q.st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st.tdre <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sck,
    output logic              sdo,
    input  logic              sdi,
    output logic              irq_rx,
    output logic              irq_tx
);
    logic              tick, busy, load, rx_strobe, frame_done;
    logic              can_start, tx_en, rx_en;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [DIV_W-1:0]  div;
    stat_t             st;

    ssx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .load(load), .rx_strobe(rx_strobe),
        .rx_word(rx_word), .frame_done(frame_done), .tx_word(tx_word),
        .can_start(can_start), .tx_en(tx_en), .rx_en(rx_en), .div(div),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .st(st)
    );

    ssx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
    );

    ssx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .tick(tick), .can_start(can_start),
        .tx_word(tx_word), .sdi(sdi), .tx_en(tx_en), .sck(sck), .sdo(sdo),
        .busy(busy), .load(load), .rx_strobe(rx_strobe), .rx_word(rx_word),
        .frame_done(frame_done)
    );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker
    import ssx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic            busy,
    input logic            sck,
    input logic            sdo,
    input logic            tx_en,
    input logic [ST_W-1:0] st
);
    // R4
    tdre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DATA && st[ST_TDRE]) |=> !st[ST_TDRE]);

    // R7
    overrun_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[ST_ORER] && !busy) |=> !busy);

    // R8
    tend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st[ST_TEND]) |-> $past(st[ST_TDRE]));

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck) && $stable(tx_en)) |-> $stable(sdo));

    // R6
    rdrf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st[ST_RDRF]) |-> $past(busy));
endmodule

bind sync_serial_xcvr ssx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .busy(busy), .sck(sck), .sdo(sdo), .tx_en(tx_en), .st(st)
);

// File: tb/sync_serial_xcvr_test.sv
`timescale 1ns/1ps
module sync_serial_xcvr_test;
    import ssx_pkg::*;

    typedef struct packed {
        logic [3:0] div;
        logic [7:0] tx;
        logic [7:0] rx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'hA5, 8'h3C},
        '{4'd1,  8'h81, 8'h7E},
        '{4'd2,  8'h00, 8'hFF},
        '{4'd3,  8'hFF, 8'h00},
        '{4'd5,  8'h96, 8'h69},
        '{4'd15, 8'hC3, 8'h18}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck, sdo, irq_rx, irq_tx;
    logic       sdi = 1'b0;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_serial_xcvr uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .sdo(sdo), .sdi(sdi), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    // serial peer model: bytes it returns, frame by frame
    logic [7:0] slv_mem [0:15];
    logic [7:0] mosi_mem [0:15];
    logic [7:0] mosi_cur = 8'h00;
    int         per_log [0:127];
    int         rise_total = 0, fall_total = 0;
    realtime    t_fall = 0.0;

    always @(posedge sck) if (rst_n === 1'b1) begin
        mosi_cur = {mosi_cur[6:0], sdo};
        if (rise_total % 8 == 7 && rise_total / 8 < 16) mosi_mem[rise_total / 8] = mosi_cur;
        rise_total++;
    end

    always @(negedge sck) if (rst_n === 1'b1) begin
        if (fall_total < 128)
            per_log[fall_total] = (fall_total == 0) ? 0 : $rtoi((($realtime - t_fall) / 5.0) + 0.5);
        t_fall = $realtime;
        sdi = slv_mem[(fall_total / 8) % 16][7 - (fall_total % 8)];
        fall_total++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_tend();
        logic [7:0] s;
        int n = 0;
        do begin
            rd(A_STAT, s);
            n++;
        end while (!s[3] && n < 3000);
        if (!s[3]) chk(1'b0, "R8 end-of-frame flag never set", s, 8'h08);
    endtask

    task automatic per_ok(input int first, input int last, input int exp, input string tag);
        int bad = 0;
        for (int k = first; k <= last; k++) if (per_log[k] != exp) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        logic [7:0] v;
        int r0, fb;
        for (int i = 0; i < 16; i++) begin slv_mem[i] = 8'h00; mosi_mem[i] = 8'h00; end
        for (int i = 0; i < NV; i++) slv_mem[i] = VECS[i].rx;
        slv_mem[7]  = 8'h5E;
        slv_mem[8]  = 8'h11;
        slv_mem[9]  = 8'h22;
        slv_mem[10] = 8'h33;
        for (int i = 0; i < 128; i++) per_log[i] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, v);
        chk(v == 8'h01, "R1 status after reset", v, 8'h01);
        chk(sck == 1'b1, "R1 sck idle", sck, 1);
        chk(sdo == 1'b0, "R1 sdo idle", sdo, 0);
        chk(irq_rx == 1'b0 && irq_tx == 1'b0, "R1 interrupts low", {irq_rx, irq_tx}, 0);

        // table of frames: divider, transmitted byte, peer byte
        for (int i = 0; i < NV; i++) begin
            wr(A_DIV, {4'h0, VECS[i].div});
            wr(A_CTRL, 8'h03);
            wr(A_STAT, 8'h00);
            if (i == 0) chk(irq_tx == 1'b1, "R10 irq_tx with empty buffer", irq_tx, 1);
            r0 = rise_total;
            wr(A_DATA, VECS[i].tx);
            wait_tend();
            chk(rise_total - r0 == 8, "R2 pulses per frame", rise_total - r0, 8);
            per_ok(8 * i + 1, 8 * i + 7, 2 * (VECS[i].div + 1), "R2 bit period");
            chk(mosi_mem[i] == VECS[i].tx, "R3 transmitted byte", mosi_mem[i], VECS[i].tx);
            rd(A_STAT, v);
            chk(v == 8'h0B, "R6 status after frame", v, 8'h0B);
            chk(irq_rx == 1'b1, "R10 irq_rx with byte ready", irq_rx, 1);
            rd(A_DATA, v);
            chk(v == VECS[i].rx, "R3 received byte", v, VECS[i].rx);
            rd(A_STAT, v);
            chk(v == 8'h09, "R6 read clears receive flag", v, 8'h09);
            chk(irq_rx == 1'b0, "R10 irq_rx after read", irq_rx, 0);
        end

        // R9 write-zero-to-clear
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v);
        chk(v == 8'h09, "R9 writing ones keeps flags", v, 8'h09);
        wr(A_STAT, 8'hF7);
        rd(A_STAT, v);
        chk(v == 8'h01, "R9 zero clears end flag", v, 8'h01);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v);
        chk(v == 8'h01, "R9 empty flag untouched", v, 8'h01);

        // R5/R4: disabled unit holds data, second write ignored
        wr(A_CTRL, 8'h00);
        r0 = rise_total;
        wr(A_DATA, 8'hA5);
        wr(A_DATA, 8'h3C);
        repeat (60) @(negedge clk);
        chk(rise_total == r0, "R5 no frame while disabled", rise_total - r0, 0);
        rd(A_STAT, v);
        chk(v == 8'h00, "R4 empty flag cleared by write", v, 8'h00);
        wr(A_DIV, 8'h00);
        wr(A_CTRL, 8'h01);
        wait_tend();
        chk(mosi_mem[6] == 8'hA5, "R4 ignored second write", mosi_mem[6], 8'hA5);
        rd(A_STAT, v);
        chk(v == 8'h09, "R11 receive disabled keeps flag clear", v, 8'h09);
        chk(irq_tx == 1'b1, "R10 irq_tx transmit only", irq_tx, 1);
        wr(A_CTRL, 8'h00);
        chk(irq_tx == 1'b0, "R10 irq_tx gated by enable", irq_tx, 0);

        // R11 transmit disabled: sdo stays low, receive still works
        wr(A_STAT, 8'h00);
        wr(A_CTRL, 8'h02);
        wr(A_DATA, 8'hFF);
        wait_tend();
        chk(mosi_mem[7] == 8'h00, "R11 sdo low with transmit off", mosi_mem[7], 8'h00);
        rd(A_DATA, v);
        chk(v == 8'h5E, "R11 receive-only byte", v, 8'h5E);

        // R8 back-to-back then R7 overrun
        wr(A_STAT, 8'h00);
        wr(A_DIV, 8'h01);
        wr(A_CTRL, 8'h03);
        r0 = rise_total;
        wr(A_DATA, 8'h5A);
        fb = 0;
        do begin rd(A_STAT, v); fb++; end while (!v[0] && fb < 100);
        wr(A_DATA, 8'hC3);
        wait_tend();
        chk(rise_total - r0 == 16, "R8 two queued frames", rise_total - r0, 16);
        per_ok(65, 79, 4, "R8 no idle between frames");
        chk({mosi_mem[8], mosi_mem[9]} == 16'h5AC3, "R8 queued bytes in order",
            {mosi_mem[8], mosi_mem[9]}, 16'h5AC3);
        rd(A_STAT, v);
        chk(v == 8'h0F, "R7 overrun flagged", v, 8'h0F);
        rd(A_DATA, v);
        chk(v == 8'h11, "R7 first byte kept", v, 8'h11);
        r0 = rise_total;
        wr(A_DATA, 8'h77);
        repeat (60) @(negedge clk);
        chk(rise_total == r0, "R7 halted while overrun set", rise_total - r0, 0);
        rd(A_STAT, v);
        chk(v == 8'h0C, "R7 status while halted", v, 8'h0C);
        wr(A_STAT, 8'hF3);
        wait_tend();
        chk(mosi_mem[10] == 8'h77, "R7 restart after clear", mosi_mem[10], 8'h77);
        rd(A_DATA, v);
        chk(v == 8'h33, "R7 byte after restart", v, 8'h33);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule